// File: doc/BRIEF.md
# Multi-Channel Register-Mapped PWM Controller

The block is a bank of identical pulse-width modulation channels behind a small synchronous register bus. Each channel counts input clock cycles, so a period in cycles equals clock_MHz × period_ns / 1000. It drives one output pin that is active for the first `duty` cycles of each `period` and inactive for the rest. Software programs a period, a duty value, a repeat count and a control word for each channel.

Period and duty writes land in shadow registers. By default the running channel takes new shadow values at the end of its current period, so no pulse is cut short. When the build option `LOAD_ON_EN` is set, the channel ignores shadow changes while it runs. It takes them only when software writes enable = 1 again. That rewrite also restarts the period. A channel either runs without end or emits a fixed number of periods and then disables itself.

Top module: `pwm_bank`

## Requirements
- R1: After reset every output is low, every channel is disabled, and every register reads 0.
- R2: Channel c owns byte addresses c*0x20 to c*0x20+0x1F. Offset 0x0 is the 32-bit period, 0x4 the 32-bit duty, 0x8 the repeat count and 0xC the control word. The control word has bit 0 = enable, bit 1 = invert polarity and bit 2 = keep. Reads return the values written, and control bits above 2 read as 0.
- R3: A write to offset 0x10–0x1F or to an address that is not word aligned changes nothing. A read of such an address returns 0.
- R4: After the clock edge that enables a channel, its output is active for `duty` cycles and then inactive for `period - duty` cycles, and this repeats.
- R5: A duty value greater than or equal to the period gives an output that is always active. A duty of 0 gives an output that is always inactive.
- R6: With the polarity bit set, the active level is 0 and the inactive level is 1. A disabled channel drives the inactive level.
- R7: With keep = 0, the channel emits `repeat` periods (a repeat count of 0 gives one period). It then clears its enable bit and drives the inactive level.
- R8: With keep = 1, the channel runs until software clears enable. The output is inactive from the next cycle on, and enable reads back as 0.
- R9: With `LOAD_ON_EN` = 0, a period or duty write takes effect at the next period boundary. A write made on the boundary edge itself takes effect at the following boundary.
- R10: With `LOAD_ON_EN` = 1, new period and duty values take effect only when enable is written as 1 while the channel runs. That write restarts the period at count 0.
- R11: Channels are independent. Activity on one channel does not change another channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting and bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | $clog2(NUM_CH)+5 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| pwm_o | output | NUM_CH | One PWM output per channel |

## Verification
The period-boundary shadow load and a software write to the shadow register can fall on the same clock edge. The bench places a duty write on the exact edge where a period ends. It then checks, cycle by cycle, that the period which starts there still uses the old duty and that the new duty appears one period later. A second collision is the enable rewrite in load-on-enable mode. This rewrite is issued mid-period, and the bench checks that the count restarts at zero with the new duty on the very next cycle.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int DATA_W = 32;
  localparam int WIN_W  = 5;   // 0x20-byte window per channel

  typedef enum logic [1:0] {
    F_PERIOD = 2'd0,
    F_DUTY   = 2'd1,
    F_REPS   = 2'd2,
    F_CTRL   = 2'd3
  } field_e;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_POL  = 1;
  localparam int CTRL_KEEP = 2;
  localparam int CTRL_W    = 3;
endpackage

// File: rtl/pwm_bank_decode.sv
module pwm_bank_decode
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + WIN_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CH_W-1:0]   ch_o,
  output field_e            field_o,
  output logic              hit_o
);
  assign ch_o    = addr_i[ADDR_W-1:WIN_W];
  assign field_o = field_e'(addr_i[3:2]);
  // only word-aligned offsets 0x0..0xC are mapped
  assign hit_o   = (addr_i[1:0] == 2'b00) && !addr_i[4];
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter bit LOAD_ON_EN = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  field_e            field_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  period_o,
  output logic [CNT_W-1:0]  duty_o,
  output logic [CNT_W-1:0]  reps_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              pwm_o
);
  localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

  logic [CNT_W-1:0] per_sh_q, duty_sh_q, reps_q;
  logic [CNT_W-1:0] per_act_q, duty_act_q, cnt_q, rep_q;
  logic             en_q, pol_q, keep_q;
  logic             wr_ctrl, wr_en1, start, reload, last, fin;

  assign wr_ctrl = we_i && (field_i == F_CTRL);
  assign wr_en1  = wr_ctrl && wdata_i[CTRL_EN];
  assign start   = wr_en1 && !en_q;
  assign reload  = LOAD_ON_EN && wr_en1 && en_q;
  assign last    = en_q && (({1'b0, cnt_q} + ONE) >= {1'b0, per_act_q});
  assign fin     = last && !keep_q && (({1'b0, rep_q} + ONE) >= {1'b0, reps_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_sh_q  <= '0;
      duty_sh_q <= '0;
      reps_q    <= '0;
    end else if (we_i) begin
      case (field_i)
        F_PERIOD: per_sh_q  <= wdata_i[CNT_W-1:0];
        F_DUTY:   duty_sh_q <= wdata_i[CNT_W-1:0];
        F_REPS:   reps_q    <= wdata_i[CNT_W-1:0];
        default:  ;
      endcase
    end
  end

  // a control write wins over the self-stop at the end of a finite run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pol_q  <= 1'b0;
      keep_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q   <= wdata_i[CTRL_EN];
      pol_q  <= wdata_i[CTRL_POL];
      keep_q <= wdata_i[CTRL_KEEP];
    end else if (fin) begin
      en_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_act_q  <= '0;
      duty_act_q <= '0;
      cnt_q      <= '0;
      rep_q      <= '0;
    end else if (start || reload) begin
      per_act_q  <= per_sh_q;
      duty_act_q <= duty_sh_q;
      cnt_q      <= '0;
      if (start) rep_q <= '0;
    end else if (wr_ctrl && !wdata_i[CTRL_EN]) begin
      cnt_q <= '0;
    end else if (last) begin
      cnt_q <= '0;
      if (!keep_q) rep_q <= rep_q + 1'b1;
      if (!LOAD_ON_EN) begin
        per_act_q  <= per_sh_q;
        duty_act_q <= duty_sh_q;
      end
    end else if (en_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pwm_o    = (en_q && (cnt_q < duty_act_q)) ^ pol_q;
  assign period_o = per_sh_q;
  assign duty_o   = duty_sh_q;
  assign reps_o   = reps_q;
  assign ctrl_o   = {keep_q, pol_q, en_q};

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && per_act_q != '0) |-> (cnt_q < per_act_q)); // R4
  AST_START_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (en_q && cnt_q == '0)); // R4
  AST_FIN_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && !wr_ctrl) |=> !en_q); // R7
  AST_KEEP_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && keep_q && !wr_ctrl) |=> en_q); // R8
  AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !last && !start && !reload) |=> ($stable(per_act_q) && $stable(duty_act_q))); // R9
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int CNT_W      = 32,
  parameter bit LOAD_ON_EN = 1'b0,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + WIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  if (!(NUM_CH == 2 || NUM_CH == 4 || NUM_CH == 8)) begin : g_bad_ch
    $error("NUM_CH must be 2, 4 or 8");
  end
  if (CNT_W > DATA_W || CNT_W < 1) begin : g_bad_w
    $error("CNT_W must be 1..32");
  end

  logic [CH_W-1:0]   ch;
  field_e            field;
  logic              hit;
  logic [CNT_W-1:0]  per_rd  [NUM_CH];
  logic [CNT_W-1:0]  duty_rd [NUM_CH];
  logic [CNT_W-1:0]  reps_rd [NUM_CH];
  logic [CTRL_W-1:0] ctrl_rd [NUM_CH];

  pwm_bank_decode #(.NUM_CH(NUM_CH)) u_dec (
    .addr_i (bus_addr_i),
    .ch_o   (ch),
    .field_o(field),
    .hit_o  (hit)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic ch_we;
    assign ch_we = bus_sel_i && bus_we_i && hit && (ch == CH_W'(i));
    pwm_bank_chan #(.CNT_W(CNT_W), .LOAD_ON_EN(LOAD_ON_EN)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (ch_we),
      .field_i (field),
      .wdata_i (bus_wdata_i),
      .period_o(per_rd[i]),
      .duty_o  (duty_rd[i]),
      .reps_o  (reps_rd[i]),
      .ctrl_o  (ctrl_rd[i]),
      .pwm_o   (pwm_o[i])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_we_i && hit) begin
      case (field)
        F_PERIOD: bus_rdata_o = DATA_W'(per_rd[ch]);
        F_DUTY:   bus_rdata_o = DATA_W'(duty_rd[ch]);
        F_REPS:   bus_rdata_o = DATA_W'(reps_rd[ch]);
        default:  bus_rdata_o = DATA_W'(ctrl_rd[ch]);
      endcase
    end
  end

  AST_RD_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_sel_i |-> (bus_rdata_o == '0)); // R3
endmodule

// File: tb/pwm_bank_tb.sv
`timescale 1ns/1ps
module pwm_bank_tb;
  localparam int NCH = 4;
  localparam int AW  = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_le;
  logic [NCH-1:0] pwm, pwm_le;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  pwm_bank #(.NUM_CH(NCH), .CNT_W(32), .LOAD_ON_EN(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pwm_o(pwm));

  pwm_bank #(.NUM_CH(NCH), .CNT_W(32), .LOAD_ON_EN(1'b1)) u_dut_le (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_le), .pwm_o(pwm_le));

  always #2.5 clk = ~clk;

  function automatic logic [AW-1:0] ra(int ch, int off);
    return AW'(ch * 32 + off);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic put(logic [AW-1:0] a, logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    put(a, d);
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [31:0] exp, string tag, bit le = 1'b0);
    logic [31:0] v;
    sel = 1'b1; we = 1'b0; addr = a;
    #1;
    v = le ? rdata_le : rdata;
    chk(v == exp, tag, v, exp);
    sel = 1'b0;
  endtask

  task automatic tick(int ch, bit exp, string tag, bit le = 1'b0);
    logic lvl;
    lvl = le ? pwm_le[ch] : pwm[ch];
    chk(lvl == exp, tag, 32'(lvl), 32'(exp));
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic t_reset();
    chk(pwm == '0 && pwm_le == '0, "R1 outputs", 32'(pwm), 0);
    for (int c = 0; c < NCH; c++) begin
      for (int o = 0; o < 16; o += 4) rd(ra(c, o), 0, "R1 regs");
    end
  endtask

  task automatic t_regs();
    wr(ra(1, 0), 32'hDEADBEEF);
    wr(ra(1, 4), 32'h0000_1234);
    wr(ra(1, 8), 32'h0000_0055);
    wr(ra(1, 12), 32'hFFFF_FFF6);
    wr(ra(3, 0), 32'h0000_0777);
    rd(ra(1, 0), 32'hDEADBEEF, "R2 period");
    rd(ra(1, 4), 32'h0000_1234, "R2 duty");
    rd(ra(1, 8), 32'h0000_0055, "R2 repeat");
    rd(ra(1, 12), 32'h6, "R2 ctrl");
    rd(ra(3, 0), 32'h777, "R2 other window");
    wr(ra(1, 12), 0);
    wr(ra(3, 0), 0);
  endtask

  task automatic t_unmapped();
    wr(ra(0, 0), 32'h11);
    wr(ra(0, 16), 32'hAA);
    wr(ra(0, 1), 32'hBB);
    wr(ra(0, 28), 32'hCC);
    wr(ra(0, 13), 32'h1);
    rd(ra(0, 16), 0, "R3 read 0x10");
    rd(ra(0, 28), 0, "R3 read 0x1C");
    rd(ra(0, 1), 0, "R3 read misaligned");
    rd(ra(0, 0), 32'h11, "R3 period untouched");
    rd(ra(0, 12), 0, "R3 ctrl untouched");
    chk(pwm[0] == 1'b0, "R3 no enable", 32'(pwm[0]), 0);
  endtask

  task automatic t_finite();
    wr(ra(1, 0), 4); wr(ra(1, 4), 1); wr(ra(1, 8), 3); wr(ra(1, 12), 1);
    for (int k = 0; k < 12; k++) tick(1, (k % 4) < 1, "R7 R4 wave");
    chk(pwm[1] == 1'b0, "R7 stopped", 32'(pwm[1]), 0);
    rd(ra(1, 12), 0, "R7 enable cleared");
    wr(ra(1, 0), 3); wr(ra(1, 4), 2); wr(ra(1, 8), 0); wr(ra(1, 12), 1);
    for (int k = 0; k < 3; k++) tick(1, k < 2, "R7 single period");
    chk(pwm[1] == 1'b0, "R7 zero repeat stop", 32'(pwm[1]), 0);
    rd(ra(1, 12), 0, "R7 zero repeat enable");
  endtask

  task automatic t_keep();
    wr(ra(1, 0), 5); wr(ra(1, 4), 2); wr(ra(1, 8), 1); wr(ra(1, 12), 5);
    for (int k = 0; k < 20; k++) tick(1, (k % 5) < 2, "R8 R4 continuous");
    rd(ra(1, 12), 5, "R8 still enabled");
    wr(ra(1, 12), 4);
    chk(pwm[1] == 1'b0, "R8 disable", 32'(pwm[1]), 0);
    rd(ra(1, 12), 4, "R8 enable reads 0");
  endtask

  task automatic t_shadow();
    int d;
    wr(ra(0, 0), 8); wr(ra(0, 4), 4); wr(ra(0, 12), 5);
    for (int k = 0; k < 32; k++) begin
      d = (k < 8) ? 4 : (k < 24) ? 2 : 6;
      if (k == 2)  put(ra(0, 4), 2);
      if (k == 15) put(ra(0, 4), 6);   // lands on the boundary edge
      chk(pwm[1] == 1'b0 && pwm[2] == 1'b0, "R11 idle channels", 32'(pwm), 0);
      tick(0, (k % 8) < d, "R9 shadow load");
    end
    wr(ra(0, 12), 0);
  endtask

  task automatic t_enload();
    wr(ra(2, 0), 6); wr(ra(2, 4), 3); wr(ra(2, 12), 5);
    for (int k = 0; k < 15; k++) begin
      if (k == 5)  put(ra(2, 4), 1);
      if (k == 10) rd(ra(2, 4), 1, "R10 shadow readback", 1'b1);
      if (k == 14) put(ra(2, 12), 5);
      tick(2, (k % 6) < 3, "R10 old values kept", 1'b1);
    end
    for (int j = 0; j < 12; j++) tick(2, (j % 6) < 1, "R10 restart new duty", 1'b1);
    wr(ra(2, 12), 0);
  endtask

  task automatic t_edge();
    wr(ra(3, 0), 4); wr(ra(3, 4), 4); wr(ra(3, 12), 5);
    for (int k = 0; k < 8; k++) tick(3, 1'b1, "R5 duty equals period");
    wr(ra(3, 12), 0); wr(ra(3, 4), 9); wr(ra(3, 12), 5);
    for (int k = 0; k < 8; k++) tick(3, 1'b1, "R5 duty above period", 1'b1);
    wr(ra(3, 12), 0); wr(ra(3, 4), 0); wr(ra(3, 12), 5);
    for (int k = 0; k < 8; k++) tick(3, 1'b0, "R5 duty zero");
    wr(ra(3, 12), 0);
  endtask

  task automatic t_pol();
    wr(ra(3, 12), 2);
    chk(pwm[3] == 1'b1, "R6 disabled inverted", 32'(pwm[3]), 1);
    wr(ra(3, 0), 4); wr(ra(3, 4), 1); wr(ra(3, 12), 7);
    for (int k = 0; k < 8; k++) tick(3, !((k % 4) < 1), "R6 inverted wave");
    wr(ra(3, 12), 2);
    chk(pwm[3] == 1'b1, "R6 stop to inactive", 32'(pwm[3]), 1);
    wr(ra(3, 12), 0);
    chk(pwm[3] == 1'b0, "R6 normal idle", 32'(pwm[3]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_unmapped();
    t_finite();
    t_keep();
    t_shadow();
    t_enload();
    t_edge();
    t_pol();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog (all requirements): actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule